// File: doc/BRIEF.md
# Received Pause Transmit Gate

This block sits in the transmit path of a gigabit MAC running one byte per clock. When the receive side has decoded a flow-control pause frame, it hands this block a one-cycle pulse and the frame's 16-bit quanta value. The block then holds off new transmit frames for that number of quanta. Each quanta is 512 bit times, which is 64 clocks at this interface width. A frame that is already on the wire is allowed to finish. The countdown starts only once that frame has ended.

A pause frame that carries a quanta value of zero acts as a resume. It ends any wait at once, whether the wait is still deferred behind a frame or already counting down. A nonzero request that arrives during a wait replaces whatever time is left. A configuration bit lets the MAC ignore received pauses entirely. The transmit scheduler starts a frame only while `tx_allow` is high. The `paused` flag reports the countdown phase.

Top module: `rx_pause_tx_gate`

## Requirements
- R1: A nonzero pause request that arrives while a frame is in progress (`tx_busy` high) does not raise `paused` while that frame lasts. `tx_allow` goes low from the cycle after the request.
- R2: A nonzero pause request with value Q that arrives while no frame is in progress raises `paused` from the next cycle for exactly Q×64 cycles. `tx_allow` is low for that whole time.
- R3: After the countdown expires, `paused` is low and `tx_allow` is high again.
- R4: A request deferred behind a frame starts its countdown in the first cycle in which `tx_busy` is sampled low. `paused` is high from the cycle after that, for Q×64 cycles.
- R5: A pause request with quanta 0x0000 clears both an active countdown and a deferred request. From the next cycle, `paused` is low and `tx_allow` is high.
- R6: A nonzero request that arrives during an active countdown reloads it with the new Q×64. The old remainder is discarded.
- R7: While `ignore_pause` is high, `tx_allow` is high and pause requests have no effect. Raising it during a countdown drops `paused` in the next cycle.
- R8: After reset, `tx_allow` is high and `paused` is low.
- R9: A `sof_req` that is granted in the same cycle as a pause request counts as a frame in progress. The request is therefore deferred as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock of the transmit interface |
| rst_n | input | 1 | Synchronous active-low reset |
| pause_valid | input | 1 | One-cycle pulse: a pause frame was decoded |
| pause_quanta | input | 16 | Quanta value carried by that frame |
| tx_busy | input | 1 | A transmit frame is in progress |
| sof_req | input | 1 | Scheduler asks to start a frame this cycle |
| ignore_pause | input | 1 | Configuration: disregard received pauses |
| tx_allow | output | 1 | New frames may start |
| paused | output | 1 | Countdown of a pause is running |

## Verification
The assertions assume three things about the inputs. First, `pause_valid` is a single-cycle pulse. Second, `tx_busy` never rises while `tx_allow` is low. Third, a frame in progress eventually ends. The stimulus follows these rules: it starts frames only while `tx_allow` is high, and it always lowers `tx_busy` or `sof_req` after a bounded number of cycles. Under these assumptions, the no-cut property and the deferred-hold property describe real scheduler behaviour rather than impossible input.

// File: rtl/pause_gate_pkg.sv
// Package: shared sizing for the pause transmit gate.
// Assumes a byte-wide interface, so one quanta (512 bit times) spans 2**6 clocks.
package pause_gate_pkg;
    localparam int QUANTA_BITS = 16;
    localparam int SLOT_SHIFT  = 6;
    localparam int COUNT_BITS  = QUANTA_BITS + SLOT_SHIFT;
endpackage

// File: rtl/pause_defer.sv
// Module: holds a nonzero pause request while a frame is still being sent.
// Assumes clear has priority over set, and set has priority over release.
module pause_defer #(
    parameter int QW = pause_gate_pkg::QUANTA_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic [QW-1:0] set_quanta,
    input  logic          clear,
    input  logic          release_req,
    output logic          pending,
    output logic [QW-1:0] pend_quanta
);
    logic          pend_q;
    logic [QW-1:0] quanta_q;

    // Capture, replace, or drop the deferred request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            quanta_q <= '0;
        end else if (clear) begin
            pend_q   <= 1'b0;
        end else if (set) begin
            pend_q   <= 1'b1;
            quanta_q <= set_quanta;
        end else if (release_req) begin
            pend_q   <= 1'b0;
        end
    end

    assign pending     = pend_q;
    assign pend_quanta = quanta_q;

    AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !clear && !set && !release_req |=> pend_q && $stable(quanta_q)); // R1
endmodule

// File: rtl/pause_countdown.sv
// Module: counts a pause down in byte clocks, quanta scaled by 2**SH.
// Assumes clear has priority over load; active is high while the count is nonzero.
module pause_countdown #(
    parameter int QW = pause_gate_pkg::QUANTA_BITS,
    parameter int SH = pause_gate_pkg::SLOT_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [QW-1:0] load_quanta,
    input  logic          clear,
    output logic          active
);
    localparam int CW = QW + SH;
    logic [CW-1:0] cnt_q;

    // Load scaled quanta, clear on resume, otherwise decrement to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= {load_quanta, {SH{1'b0}}};
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign active = (cnt_q != '0);

    AST_LOAD_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        load && !clear |=> cnt_q == {$past(load_quanta), {SH{1'b0}}}); // R6
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        active && !load && !clear |=> cnt_q == $past(cnt_q) - CW'(1)); // R2
endmodule

// File: rtl/rx_pause_tx_gate.sv
// Module: gates new transmit frames after a received pause request.
// Assumes pause_valid is a one-cycle pulse and tx_busy only rises while tx_allow is high.
module rx_pause_tx_gate #(
    parameter int QUANTA_W = pause_gate_pkg::QUANTA_BITS,
    parameter int SHIFT    = pause_gate_pkg::SLOT_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pause_valid,
    input  logic [QUANTA_W-1:0] pause_quanta,
    input  logic                tx_busy,
    input  logic                sof_req,
    input  logic                ignore_pause,
    output logic                tx_allow,
    output logic                paused
);
    logic                frame_active, evt, evt_zero, evt_nz;
    logic                defer_set, direct_load, release_req;
    logic                pending, cnt_load, cnt_clear, pend_clear;
    logic [QUANTA_W-1:0] pend_quanta, load_quanta;

    // Decode the pause event and route it to the defer or countdown path.
    always_comb begin
        frame_active = tx_busy | (sof_req & tx_allow);
        evt          = pause_valid & ~ignore_pause;
        evt_zero     = evt & (pause_quanta == '0);
        evt_nz       = evt & (pause_quanta != '0);
        defer_set    = evt_nz & frame_active;
        direct_load  = evt_nz & ~frame_active;
        release_req  = pending & ~frame_active & ~evt;
        cnt_clear    = ignore_pause | evt_zero;
        cnt_load     = direct_load | release_req;
        pend_clear   = ignore_pause | evt_zero | direct_load;
        load_quanta  = direct_load ? pause_quanta : pend_quanta;
    end

    pause_defer #(.QW(QUANTA_W)) u_defer (
        .clk         (clk),
        .rst_n       (rst_n),
        .set         (defer_set),
        .set_quanta  (pause_quanta),
        .clear       (pend_clear),
        .release_req (release_req),
        .pending     (pending),
        .pend_quanta (pend_quanta)
    );

    pause_countdown #(.QW(QUANTA_W), .SH(SHIFT)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cnt_load),
        .load_quanta (load_quanta),
        .clear       (cnt_clear),
        .active      (paused)
    );

    // Permit new frames unless a pause is deferred or counting.
    assign tx_allow = ignore_pause | ~(pending | paused);

    AST_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && !paused |=> !paused); // R1
    AST_ZERO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid && !ignore_pause && pause_quanta == '0 |=> !paused && !pending); // R5
    AST_IGNORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ignore_pause |=> !paused && !pending); // R7
    AST_DEFER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid && !ignore_pause && pause_quanta != '0 && tx_busy |=> pending && !paused); // R1
endmodule

// File: tb/tb_rx_pause_tx_gate.sv
module tb_rx_pause_tx_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pause_valid = 1'b0;
    logic [15:0] pause_quanta = '0;
    logic        tx_busy = 1'b0;
    logic        sof_req = 1'b0;
    logic        ignore_pause = 1'b0;
    logic        tx_allow, paused;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    rx_pause_tx_gate dut (
        .clk(clk), .rst_n(rst_n), .pause_valid(pause_valid), .pause_quanta(pause_quanta),
        .tx_busy(tx_busy), .sof_req(sof_req), .ignore_pause(ignore_pause),
        .tx_allow(tx_allow), .paused(paused)
    );

    localparam int NV = 5;
    localparam logic [15:0] VQ   [NV] = '{16'd1, 16'd2, 16'd3, 16'd16, 16'd0};
    localparam int          VLEN [NV] = '{64, 128, 192, 1024, 0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] q);
        pause_valid  = 1'b1;
        pause_quanta = q;
        @(negedge clk);
        pause_valid  = 1'b0;
        pause_quanta = '0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (paused && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(tx_allow == 1'b1, "R8 tx_allow", tx_allow, 1);
        check(paused == 1'b0, "R8 paused", paused, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 table of quanta and expected pause lengths
        for (int i = 0; i < NV; i++) begin
            pulse(VQ[i]);
            if (VLEN[i] != 0) check(tx_allow == 1'b0, "R2 gate", tx_allow, 0);
            measure(n);
            check(n == VLEN[i], "R2 length", n, VLEN[i]);
            check(tx_allow == 1'b1, "R3 resume", tx_allow, 1);
            repeat (2) @(negedge clk);
        end

        // R1 and R4: request during a frame is deferred
        tx_busy = 1'b1;
        pulse(16'd1);
        check(paused == 1'b0, "R1 no cut", paused, 0);
        check(tx_allow == 1'b0, "R1 gate", tx_allow, 0);
        repeat (10) @(negedge clk);
        check(paused == 1'b0, "R1 still sending", paused, 0);
        tx_busy = 1'b0;
        @(negedge clk);
        check(paused == 1'b1, "R4 start", paused, 1);
        measure(n);
        check(n == 64, "R4 length", n, 64);

        // R5: zero quanta cancels a running countdown
        pulse(16'd5);
        repeat (10) @(negedge clk);
        pulse(16'd0);
        check(paused == 1'b0, "R5 cancel paused", paused, 0);
        check(tx_allow == 1'b1, "R5 cancel allow", tx_allow, 1);

        // R5: zero quanta cancels a deferred request
        tx_busy = 1'b1;
        pulse(16'd3);
        pulse(16'd0);
        check(tx_allow == 1'b1, "R5 cancel deferred", tx_allow, 1);
        tx_busy = 1'b0;
        repeat (2) @(negedge clk);
        check(paused == 1'b0, "R5 stays idle", paused, 0);

        // R6: reload during an active countdown
        pulse(16'd4);
        repeat (100) @(negedge clk);
        pulse(16'd1);
        measure(n);
        check(n == 64, "R6 reload length", n, 64);

        // R7: ignore bit masks requests and drops an active pause
        ignore_pause = 1'b1;
        pulse(16'd7);
        repeat (3) @(negedge clk);
        check(tx_allow == 1'b1, "R7 allow", tx_allow, 1);
        check(paused == 1'b0, "R7 no pause", paused, 0);
        ignore_pause = 1'b0;
        @(negedge clk);
        check(paused == 1'b0, "R7 dropped request", paused, 0);
        pulse(16'd2);
        repeat (5) @(negedge clk);
        ignore_pause = 1'b1;
        @(negedge clk);
        check(paused == 1'b0, "R7 drop active", paused, 0);
        ignore_pause = 1'b0;
        repeat (2) @(negedge clk);

        // R9: granted start of frame in the same cycle defers the request
        sof_req = 1'b1;
        pulse(16'd1);
        sof_req = 1'b0;
        check(paused == 1'b0, "R9 deferred", paused, 0);
        check(tx_allow == 1'b0, "R9 gate", tx_allow, 0);
        @(negedge clk);
        check(paused == 1'b1, "R9 start", paused, 1);
        measure(n);
        check(n == 64, "R9 length", n, 64);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule